// File: doc/BRIEF.md
# Unlock-Guarded System Clock Divider

This block divides a master clock by a power of two and presents the divide choice as one 8-bit register on a simple write port. The master clock itself is never gated. The block issues a clock-enable pulse that lasts one master cycle, and every synchronous consumer that qualifies on this pulse runs at the divided rate.

The divide select field is protected against stray writes. Software first writes an exact unlock pattern. It then has a short, fixed window of master cycles in which to write the new select value. The window cannot be stretched, and any write outside it has no effect on the select field.

A fuse input picks the reset value of the select field, either divide-by-1 or divide-by-8. A new divide setting takes effect only at the next enable pulse, so the clock never produces a runt period.

Top module: `pdr_clkdiv`

## Requirements
- R1: The read value carries the unlock flag in bit 7, zeros in bits 6..4, and the current divide select in bits 3..0.
- R2: The unlock flag is set only by a write of exactly 8'h80. A write of any other value, for example 8'h81, leaves the unlock flag clear.
- R3: While the unlock flag is set, a write with bit 7 equal to 0 loads bits 3..0 into the select field and clears the unlock flag in the same cycle. This holds for a write in any of the four master cycles that follow the unlock write.
- R4: A write with bit 7 equal to 0 leaves the select field unchanged if it arrives while the unlock flag is clear. This includes a write in the fifth cycle after the unlock write.
- R5: If no select write arrives, the unlock flag clears on its own exactly four master cycles after it was set, and it reads as 0 from then on.
- R6: Writing 8'h80 again while the unlock flag is set neither clears the flag nor restarts the four-cycle window.
- R7: On synchronous active-low reset the unlock flag clears. The select field resets to 4'b0011 when the fuse input is high and to 4'b0000 when it is low.
- R8: For select values 0 through 8, the enable pulse repeats every 2^select master cycles.
- R9: Select values 9 through 15 give a period of 256 master cycles.
- R10: A select change alters the spacing only from the next enable pulse onward. The gap after each pulse equals the factor of the select value present in that pulse's cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fuse_div8 | input | 1 | Selects the reset value of the divide select (1: select 3) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| clk_en | output | 1 | One-cycle enable pulse at the divided rate |

## Verification
The bench probes the edges of the unlock window. It places a select write in the fourth cycle after the unlock write, where it must land, and another in the fifth cycle, where it must be ignored. A design with an off-by-one window would either drop the first write or accept the second. A repeated unlock write checks that the timeout is not re-armed, since a design that restarts the timeout would keep the flag set past the fourth cycle. The bench also changes the select value in the middle of a divide period and uses a reserved select value. A divider that reloads immediately would show a short gap, and one that treats reserved values literally would overflow its counter and show a wrong period.

// File: rtl/pdr_pkg.sv
// Package: shared sizing constants for the protected clock divider.
// Assumes an 8-bit register with the flag at the top and a 4-bit select.
package pdr_pkg;
    localparam int DATA_W   = 8;
    localparam int SEL_W    = 4;
    localparam int FLAG_BIT = 7;
    localparam logic [DATA_W-1:0] UNLOCK_KEY = 8'h80;
endpackage

// File: rtl/pdr_lock.sv
// Module: pdr_lock
// Holds the unlock flag, its timeout counter and the divide select register.
// Assumes one write per cycle on a simple strobe/data port; the timeout
// counts master cycles.
module pdr_lock
    import pdr_pkg::*;
#(
    parameter int WINDOW   = 4,
    parameter int FUSE_SEL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fuse_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              unlock_o,
    output logic [SEL_W-1:0]  sel_o
);
    localparam int TW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [TW-1:0] T_INIT = TW'(WINDOW - 1);

    logic          unlock_q;
    logic [TW-1:0] tmo_q;
    logic [SEL_W-1:0] sel_q;
    logic          key_wr;
    logic          sel_wr;

    // Decode the two kinds of write that matter.
    always_comb begin
        key_wr = wr_en_i && (wr_data_i == UNLOCK_KEY) && !unlock_q;
        sel_wr = wr_en_i && !wr_data_i[FLAG_BIT] && unlock_q;
    end

    // Unlock flag with a fixed, non-extendable timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlock_q <= 1'b0;
            tmo_q    <= '0;
        end else if (key_wr) begin
            unlock_q <= 1'b1;
            tmo_q    <= T_INIT;
        end else if (unlock_q) begin
            if (sel_wr || tmo_q == '0) unlock_q <= 1'b0;
            else                       tmo_q    <= tmo_q - 1'b1;
        end
    end

    // Select register, loaded from the fuse on reset or by a guarded write.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= fuse_i ? SEL_W'(FUSE_SEL) : '0;
        else if (sel_wr) sel_q <= wr_data_i[SEL_W-1:0];
    end

    assign unlock_o = unlock_q;
    assign sel_o    = sel_q;

    // R5
    flag_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(unlock_q && $past(unlock_q,1) && $past(unlock_q,2)
          && $past(unlock_q,3) && $past(unlock_q,4)));
    // R4
    sel_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != $past(sel_q)) |-> $past(unlock_q));
    // R3
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_q && wr_en_i && !wr_data_i[FLAG_BIT])
        |=> (sel_q == $past(wr_data_i[SEL_W-1:0])) && !unlock_o);
    // R6
    rekey_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_q && wr_en_i && wr_data_i == UNLOCK_KEY && tmo_q != '0)
        |=> unlock_o);
    // R2
    key_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlock_q && !(wr_en_i && wr_data_i == UNLOCK_KEY)) |=> !unlock_o);
endmodule

// File: rtl/pdr_rate.sv
// Module: pdr_rate
// Power-of-two divider producing a one-cycle enable pulse.
// Assumes the select input may change at any time; it is sampled only
// in the cycle of a pulse, so periods never shrink mid-way.
module pdr_rate
    import pdr_pkg::*;
#(
    parameter int MAX_LOG = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic             en_o
);
    localparam int CW = MAX_LOG;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] reload;
    int            eff;

    // Clamp reserved selects and derive the reload value.
    always_comb begin
        eff    = (int'(sel_i) > MAX_LOG) ? MAX_LOG : int'(sel_i);
        reload = {CW{1'b1}} >> (MAX_LOG - eff);
    end

    // Down-counter; reloads only at a pulse boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q == '0)  cnt_q <= reload;
        else                   cnt_q <= cnt_q - 1'b1;
    end

    assign en_o = (cnt_q == '0);

    // R8
    pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && sel_i != '0) |=> !en_o);
    // R8
    full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && sel_i == '0) |=> en_o);
endmodule

// File: rtl/pdr_clkdiv.sv
// Module: pdr_clkdiv (top)
// Register-mapped clock divider with an unlock-guarded select field.
// Assumes software keeps interrupts off across the two-write sequence.
module pdr_clkdiv
    import pdr_pkg::*;
#(
    parameter int WINDOW   = 4,
    parameter int FUSE_SEL = 3,
    parameter int MAX_LOG  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fuse_div8,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              clk_en
);
    logic             unlock;
    logic [SEL_W-1:0] sel;

    pdr_lock #(.WINDOW(WINDOW), .FUSE_SEL(FUSE_SEL)) u_lock (
        .clk(clk), .rst_n(rst_n), .fuse_i(fuse_div8),
        .wr_en_i(wr_en), .wr_data_i(wr_data),
        .unlock_o(unlock), .sel_o(sel)
    );

    pdr_rate #(.MAX_LOG(MAX_LOG)) u_rate (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .en_o(clk_en)
    );

    // Readback assembly: flag, zero pad, select.
    always_comb begin
        rd_data = '0;
        rd_data[FLAG_BIT]    = unlock;
        rd_data[SEL_W-1:0]   = sel;
    end

    // R1
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[FLAG_BIT-1:SEL_W] == '0);
endmodule

// File: tb/sim_pdr_clkdiv.sv
`timescale 1ns/1ps
module sim_pdr_clkdiv;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fuse_div8 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       clk_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    // model of the register from the requirements
    bit       m_unlock;
    int       m_left;
    bit [3:0] m_sel;

    always #2 clk = ~clk;

    pdr_clkdiv u0 (.clk(clk), .rst_n(rst_n), .fuse_div8(fuse_div8),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .clk_en(clk_en));

    // scoreboard monitor: compare the register readback
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_data !== e) begin
                fails++;
                $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
            end
        end
    end

    // divider monitor: gap after each pulse follows the select at that pulse (R8, R9, R10)
    int gap = 0;
    int exp_gap = 0;
    bit have = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            have = 0;
            gap  = 0;
        end else begin
            gap++;
            if (clk_en) begin
                if (have) begin
                    checks++;
                    if (gap != exp_gap) begin
                        fails++;
                        $display("FAIL %s: pulse gap=%0d expected=%0d",
                                 (exp_gap == 256) ? "R9" : "R8/R10", gap, exp_gap);
                    end
                end
                have = 1;
                gap  = 0;
                exp_gap = 1 << ((rd_data[3:0] > 8) ? 8 : rd_data[3:0]);
            end
        end
    end

    task automatic tick(input bit we, input logic [7:0] d, input string tag);
        @(negedge clk);
        wr_en   = we;
        wr_data = d;
        @(posedge clk);
        if (we && !m_unlock && d == 8'h80) begin
            m_unlock = 1;
            m_left   = 3;
        end else if (m_unlock) begin
            if (we && !d[7]) begin
                m_sel    = d[3:0];
                m_unlock = 0;
            end else if (m_left == 0) m_unlock = 0;
            else m_left--;
        end
        exp_q.push_back({m_unlock, 3'b000, m_sel});
        tag_q.push_back(tag);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic do_reset(input bit fuse);
        @(negedge clk);
        rst_n = 1'b0;
        fuse_div8 = fuse;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_unlock = 0;
        m_left   = 0;
        m_sel    = fuse ? 4'd3 : 4'd0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(0, 8'h00, tag);
    endtask

    initial begin
        // R7: fuse high gives select 3
        do_reset(1);
        idle(1, "R7");
        idle(40, "R8");
        // R7: fuse low gives select 0
        do_reset(0);
        idle(3, "R7");
        // R4: locked select write ignored
        tick(1, 8'h05, "R4");
        // R2: near-miss key does not unlock
        tick(1, 8'h81, "R2");
        tick(1, 8'hC0, "R2");
        // R1/R3: unlock, then write in third cycle
        tick(1, 8'h80, "R1");
        idle(2, "R1");
        tick(1, 8'h05, "R3");
        idle(70, "R8");
        // R3: write on the fourth cycle lands
        tick(1, 8'h80, "R3");
        idle(3, "R3");
        tick(1, 8'h07, "R3");
        idle(300, "R10");
        // R5 then R4: timeout, and the fifth-cycle write is ignored
        tick(1, 8'h80, "R5");
        idle(4, "R5");
        tick(1, 8'h02, "R4");
        // R6: second key write does not extend or clear
        tick(1, 8'h80, "R6");
        tick(1, 8'h80, "R6");
        idle(3, "R6");
        tick(1, 8'h01, "R6");
        // R9: reserved select behaves as 256
        tick(1, 8'h80, "R9");
        tick(1, 8'h0C, "R9");
        idle(800, "R9");
        // R8/R10: change mid-period to 8, then 3, then 0
        tick(1, 8'h80, "R10");
        tick(1, 8'h08, "R10");
        idle(600, "R8");
        tick(1, 8'h80, "R8");
        tick(1, 8'h03, "R8");
        idle(60, "R8");
        tick(1, 8'h80, "R8");
        tick(1, 8'h00, "R8");
        idle(300, "R10");
        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule